// File: doc/BRIEF.md
# GPIO Bank with Grouped Interrupt Causes

This block is a bank of 32 general-purpose I/O lines behind a plain 32-bit register bus. The bus has a word address, a write strobe, write data and read data. Software sets the line directions, the driven output values and a per-line input inversion. It reads back the synchronised, inversion-adjusted pad levels. Each pad line drives an output value together with its own output-enable, so the tristate buffer can sit at the chip edge.

Every line can raise an interrupt in two ways. A level source is the adjusted input itself. An edge source is a sticky latch that records a 0-to-1 step of the adjusted input. Software clears the latch by writing zeros to it. Each source has its own enable mask. The enabled causes of a line are ORed together. The lines are then summarised into four group outputs, one for each run of eight lines. An interrupt controller samples these outputs.

Register word index (byte offset = index x 4):

| Index | Contents |
|---|---|
| 0 | driven output values |
| 1 | direction, 1 = input |
| 2 | blink enable (storage only) |
| 3 | input inversion |
| 4 | adjusted input (read only) |
| 5 | edge latch |
| 6 | edge enable mask |
| 7 | level enable mask |
| 8 | blink counter select (storage only) |

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the direction register holds all ones, so pad_oe is zero on every line. The output, inversion, edge latch, both masks and both blink registers hold zero. All four irq_grp outputs are low.
- R2: A write to word index 0, 1, 3, 6 or 7 stores bus_wdata, and a read of the same index returns it. pad_out equals the index-0 register. Bit i of pad_oe is the inverse of direction bit i (direction 1 = input, 0 = driven).
- R3: Index 4 reads the pad value after two clock stages, XOR the index-3 inversion register. A pad change is visible there after the second rising edge. Writes to index 4 have no effect.
- R4: An edge latch bit is set one clock after its adjusted input goes from 0 to 1. A 1-to-0 step of the adjusted input leaves the bit clear. Because inversion is applied first, a falling pad on an inverted line sets the bit, and so does flipping the inversion bit while the pad is steady low.
- R5: A write to index 5 clears each latch bit written as 0 and leaves each bit written as 1 unchanged. Between writes, a set bit stays set.
- R6: If an index-5 write clears a bit in the same cycle that a new rising step arrives on that line, the bit ends up set.
- R7: The level cause of line i is adjusted input bit i AND level mask bit i.
- R8: The cause of line i is its level cause OR (edge latch bit i AND edge mask bit i). irq_grp[g] is the OR of the causes of lines 8g to 8g+7, with no register in that path.
- R9: Index 2 and index 8 store and read back what was written. They do not change pad_out, pad_oe or irq_grp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register word index |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 32 | Raw pad levels, asynchronous |
| pad_out | output | 32 | Driven pad values |
| pad_oe | output | 32 | Per-line output enable, 1 = drive |
| irq_grp | output | 4 | Grouped interrupt outputs, one per eight lines |

## Verification
The bench builds the block with its default parameters: 32 lines, a four-bit word index and groups of eight. With these values the group boundaries can be reached directly; lines 0, 9, 20 and 31 each land in a different irq_grp bit. The default two-stage synchroniser fixes the latency: adjusted input after two edges, edge latch after three. That makes the clear-versus-new-edge collision reproducible on a chosen cycle. The same settings let a write to the inversion register create an edge with no pad activity.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [3:0] {
    SEL_OUT   = 4'd0,
    SEL_DIR   = 4'd1,
    SEL_BLINK = 4'd2,
    SEL_POL   = 4'd3,
    SEL_DIN   = 4'd4,
    SEL_CAUSE = 4'd5,
    SEL_EMASK = 4'd6,
    SEL_LMASK = 4'd7,
    SEL_BSEL  = 4'd8
  } reg_sel_e;

  // Per-line cause: level source OR masked edge latch.
  function automatic logic [31:0] line_cause_f(input logic [31:0] din,
                                               input logic [31:0] lmask,
                                               input logic [31:0] latch,
                                               input logic [31:0] emask);
    return (din & lmask) | (latch & emask);
  endfunction

  // Next edge latch: keep bits written 1 (or all when idle), then add new rises.
  function automatic logic [31:0] latch_next_f(input logic [31:0] cur,
                                               input logic        wr,
                                               input logic [31:0] keep,
                                               input logic [31:0] rise);
    return (wr ? (cur & keep) : cur) | rise;
  endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_edge.sv
module gpio_bank_edge
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] adj_in,
  input  logic             clr_wr,
  input  logic [WIDTH-1:0] clr_keep,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] prev_q;

  assign rise = adj_in & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= adj_in;
      latch_q <= latch_next_f(latch_q, clr_wr, clr_keep, rise);
    end
  end
endmodule

// File: rtl/gpio_bank_reduce.sv
module gpio_bank_reduce #(
  parameter int WIDTH = 32,
  parameter int GROUP = 8,
  localparam int NGRP = WIDTH / GROUP
) (
  input  logic [WIDTH-1:0] cause,
  output logic [NGRP-1:0]  grp
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp[g] = |cause[g*GROUP +: GROUP];
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int LINES   = 32,
  parameter int GROUP   = 8,
  parameter int ADDR_W  = 4,
  parameter int SYNC_ST = 2,
  localparam int NGRP   = LINES / GROUP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [LINES-1:0]  bus_wdata,
  output logic [LINES-1:0]  bus_rdata,
  input  logic [LINES-1:0]  pad_in,
  output logic [LINES-1:0]  pad_out,
  output logic [LINES-1:0]  pad_oe,
  output logic [NGRP-1:0]   irq_grp
);
  logic [LINES-1:0] out_q, dir_q, blink_q, pol_q, emask_q, lmask_q, bsel_q;
  logic [LINES-1:0] pad_sync, data_in, rise_vec, edge_latch, line_cause;
  logic             latch_wr;

  gpio_bank_sync #(.WIDTH(LINES), .STAGES(SYNC_ST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
  );

  assign data_in  = pad_sync ^ pol_q;
  assign latch_wr = bus_we && (bus_addr == ADDR_W'(SEL_CAUSE));

  gpio_bank_edge #(.WIDTH(LINES)) u_edge (
    .clk(clk), .rst_n(rst_n), .adj_in(data_in), .clr_wr(latch_wr),
    .clr_keep(bus_wdata), .latch_q(edge_latch), .rise(rise_vec)
  );

  assign line_cause = line_cause_f(data_in, lmask_q, edge_latch, emask_q);

  gpio_bank_reduce #(.WIDTH(LINES), .GROUP(GROUP)) u_reduce (
    .cause(line_cause), .grp(irq_grp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= '1;
      blink_q <= '0;
      pol_q   <= '0;
      emask_q <= '0;
      lmask_q <= '0;
      bsel_q  <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        ADDR_W'(SEL_OUT):   out_q   <= bus_wdata;
        ADDR_W'(SEL_DIR):   dir_q   <= bus_wdata;
        ADDR_W'(SEL_BLINK): blink_q <= bus_wdata;
        ADDR_W'(SEL_POL):   pol_q   <= bus_wdata;
        ADDR_W'(SEL_EMASK): emask_q <= bus_wdata;
        ADDR_W'(SEL_LMASK): lmask_q <= bus_wdata;
        ADDR_W'(SEL_BSEL):  bsel_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_W'(SEL_OUT):   bus_rdata = out_q;
      ADDR_W'(SEL_DIR):   bus_rdata = dir_q;
      ADDR_W'(SEL_BLINK): bus_rdata = blink_q;
      ADDR_W'(SEL_POL):   bus_rdata = pol_q;
      ADDR_W'(SEL_DIN):   bus_rdata = data_in;
      ADDR_W'(SEL_CAUSE): bus_rdata = edge_latch;
      ADDR_W'(SEL_EMASK): bus_rdata = emask_q;
      ADDR_W'(SEL_LMASK): bus_rdata = lmask_q;
      ADDR_W'(SEL_BSEL):  bus_rdata = bsel_q;
      default:            bus_rdata = '0;
    endcase
  end

  assign pad_out = out_q;
  assign pad_oe  = ~dir_q;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int LINES  = 32,
  parameter int ADDR_W = 4,
  parameter int NGRP   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [LINES-1:0]  bus_wdata,
  input logic [LINES-1:0]  rise_vec,
  input logic [LINES-1:0]  edge_latch,
  input logic [LINES-1:0]  line_cause,
  input logic [LINES-1:0]  emask_q,
  input logic [LINES-1:0]  lmask_q,
  input logic [NGRP-1:0]   irq_grp
);
  logic latch_wr_c;
  assign latch_wr_c = bus_we && (bus_addr == ADDR_W'(5));

  AST_RISE_SETS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_vec != '0) |=> ((edge_latch & $past(rise_vec)) == $past(rise_vec))); // R6

  AST_LATCH_ONLY_FROM_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_latch & ~$past(edge_latch) & ~$past(rise_vec)) == '0)); // R4

  AST_ZERO_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    latch_wr_c |=> ((edge_latch & ~$past(bus_wdata) & ~$past(rise_vec)) == '0)); // R5

  AST_NO_CAUSE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (line_cause == '0) |-> (irq_grp == '0)); // R8

  AST_GROUP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_grp) <= $countones(line_cause)); // R8

  AST_MASKED_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((emask_q == '0) && (lmask_q == '0)) |-> (irq_grp == '0)); // R7
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.LINES(LINES), .ADDR_W(ADDR_W), .NGRP(NGRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .rise_vec(rise_vec), .edge_latch(edge_latch),
  .line_cause(line_cause), .emask_q(emask_q), .lmask_q(lmask_q), .irq_grp(irq_grp)
);

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic [3:0]  irq_grp;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_bank u_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_grp(irq_grp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_pad(input logic [31:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] r;
    chk("R1 oe", pad_oe, 32'h0);
    chk("R1 out", pad_out, 32'h0);
    chk("R1 irq", {28'h0, irq_grp}, 32'h0);
    rd(4'd1, r); chk("R1 dir", r, 32'hFFFF_FFFF);
    rd(4'd5, r); chk("R1 latch", r, 32'h0);
    rd(4'd6, r); chk("R1 emask", r, 32'h0);
    rd(4'd7, r); chk("R1 lmask", r, 32'h0);
    rd(4'd2, r); chk("R1 blink", r, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] r;
    wr(4'd0, 32'hDEAD_BEEF);
    wr(4'd1, 32'h0000_FFFF);
    rd(4'd0, r); chk("R2 out rd", r, 32'hDEAD_BEEF);
    chk("R2 pad_out", pad_out, 32'hDEAD_BEEF);
    chk("R2 pad_oe", pad_oe, 32'hFFFF_0000);
    wr(4'd1, 32'hFFFF_FFFF);
    chk("R2 pad_oe input", pad_oe, 32'h0);
  endtask

  task automatic t_datain();
    logic [31:0] r;
    @(negedge clk); pad_in = 32'hA5A5_0F0F;
    @(negedge clk);
    rd(4'd4, r); chk("R3 data-in", r, 32'hA5A5_0F0F);
    wr(4'd3, 32'hFFFF_0000);
    rd(4'd4, r); chk("R3 inverted", r, 32'h5A5A_0F0F);
    wr(4'd4, 32'h1234_5678);
    rd(4'd4, r); chk("R3 ro", r, 32'h5A5A_0F0F);
    wr(4'd3, 32'h0);
    set_pad(32'h0);
    wr(4'd5, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] r;
    set_pad(32'h0000_0008);
    rd(4'd5, r); chk("R4 rise sets", r, 32'h0000_0008);
    wr(4'd5, 32'h0);
    set_pad(32'h0);
    rd(4'd5, r); chk("R4 fall no set", r, 32'h0);
    wr(4'd3, 32'h0000_0010);
    @(negedge clk);
    rd(4'd5, r); chk("R4 inversion edge", r, 32'h0000_0010);
    wr(4'd5, 32'h0);
    set_pad(32'h0000_0010);
    rd(4'd5, r); chk("R4 inverted fall no", r, 32'h0);
    set_pad(32'h0);
    rd(4'd5, r); chk("R4 inverted falling pad", r, 32'h0000_0010);
    wr(4'd3, 32'h0);
    wr(4'd5, 32'h0);
  endtask

  task automatic t_clear();
    logic [31:0] r;
    set_pad(32'h0000_0300);
    set_pad(32'h0);
    rd(4'd5, r); chk("R5 held", r, 32'h0000_0300);
    wr(4'd5, 32'h0000_0100);
    rd(4'd5, r); chk("R5 partial clear", r, 32'h0000_0100);
    wr(4'd5, 32'h0);
    rd(4'd5, r); chk("R5 full clear", r, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] r;
    set_pad(32'h0000_0040);
    set_pad(32'h0);
    @(negedge clk); pad_in = 32'h0000_0020;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_addr = 4'd5; bus_wdata = 32'h0; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    rd(4'd5, r); chk("R6 edge wins", r, 32'h0000_0020);
    set_pad(32'h0);
    wr(4'd5, 32'h0);
  endtask

  task automatic t_level();
    set_pad(32'h0000_0200);
    chk("R7 unmasked", {28'h0, irq_grp}, 32'h0);
    wr(4'd7, 32'h0000_0200);
    chk("R7 level grp1", {28'h0, irq_grp}, 32'h2);
    wr(4'd3, 32'h0000_0200);
    chk("R7 inverted low", {28'h0, irq_grp}, 32'h0);
    wr(4'd3, 32'h0);
    wr(4'd7, 32'h0);
    set_pad(32'h0);
    wr(4'd5, 32'h0);
  endtask

  task automatic t_groups();
    set_pad(32'h8010_0001);
    set_pad(32'h0);
    chk("R8 latch only", {28'h0, irq_grp}, 32'h0);
    wr(4'd6, 32'h0010_0000);
    chk("R8 grp2", {28'h0, irq_grp}, 32'h4);
    wr(4'd6, 32'h8000_0001);
    chk("R8 grp0 grp3", {28'h0, irq_grp}, 32'h9);
    wr(4'd5, 32'h7FFF_FFFF);
    chk("R8 cleared line31", {28'h0, irq_grp}, 32'h1);
    wr(4'd5, 32'h0);
    wr(4'd6, 32'h0);
  endtask

  task automatic t_blink();
    logic [31:0] r;
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd8, 32'h1357_9BDF);
    rd(4'd2, r); chk("R9 blink rd", r, 32'hFFFF_FFFF);
    rd(4'd8, r); chk("R9 select rd", r, 32'h1357_9BDF);
    chk("R9 out unchanged", pad_out, 32'hDEAD_BEEF);
    chk("R9 oe unchanged", pad_oe, 32'h0);
    chk("R9 irq unchanged", {28'h0, irq_grp}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_datain();
    t_edge();
    t_clear();
    t_collide();
    t_level();
    t_groups();
    t_blink();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule